// File: doc/BRIEF.md
# Masked Packed Single-Precision Vector Adder

This block adds up to sixteen IEEE-754 binary32 values, lane by lane, across a 512-bit datapath. Each cycle that `valid_i` is high it takes two source vectors, the previous destination contents and a per-lane write mask. It returns the new destination vector and five exception conditions for that operation. A second set of the same five conditions stays set from one operation to the next until reset.

Control inputs choose the instruction form and the vector length. The form is legacy, plain (unmasked) or masked. In the masked form they also choose merge or zero masking, a broadcast of element 0 of the second source, and a rounding override that lasts for one operation. Every lane holds its own combinational adder. An optional register stage, on by default, puts the result one clock after the operands.

Top module: `vfadd_masked`

## Requirements
- R1: The vector length code `vlen_i` sets the number of active lanes. Code 0 gives 4 lanes, code 1 gives 8 lanes, and codes 2 and 3 give 16 lanes. Lane n occupies bits [32n+31:32n] of every vector port.
- R2: In the legacy form (`form_i`=0), lanes 0 to 3 receive the sum and lanes 4 to 15 keep `old_i`. The mask, zeroing, broadcast, override and vector length inputs have no effect in this form.
- R3: In the plain and masked forms, every lane at or above the active lane count is written with zero.
- R4: In the masked form (`form_i`=2) with `zero_i`=0, an active lane whose `wmask_i` bit is 1 receives the sum. An active lane whose mask bit is 0 keeps `old_i`.
- R5: In the masked form with `zero_i`=1, an active lane whose mask bit is 0 is written with zero.
- R6: In the plain form (`form_i`=1), the mask counts as all ones, so every active lane receives the sum.
- R7: In the masked form, when `bcast_i`=1 and `src2_reg_i`=0, every lane adds element 0 of `src2_i` in place of its own element.
- R8: The rounding mode is round-to-nearest-even. The only exception is an operation in the masked form with `vlen_i`>=2, `src2_reg_i`=1 and `bcast_i`=1. That operation alone uses `rc_i`: 0 nearest-even, 1 toward negative infinity, 2 toward positive infinity, 3 toward zero.
- R9: A sum of finite operands, including denormal operands, is correctly rounded in the selected mode. An exact zero from operands of opposite sign is +0, except toward negative infinity, where it is -0.
- R10: Opposite infinities, or any signaling NaN operand, give 0x7FC00000 and raise invalid. Otherwise a quiet NaN operand is passed on unchanged, the first source taking precedence, with no flag.
- R11: The flag bits are [4] denormal operand, [3] invalid, [2] overflow, [1] underflow (a tiny result that is inexact) and [0] inexact. `op_flags_o` is the OR over lanes that are active and enabled by the mask.
- R12: `sticky_o` ORs in the flags of every valid operation. Only reset clears it.
- R13: With `OUT_REG`=1, `dst_o`, `op_flags_o` and `valid_o` appear one clock after `valid_i`. Reset clears all outputs to zero.
- R14: On overflow, nearest-even gives infinity, toward zero gives the largest finite value, and each directed mode gives infinity only in its own direction. Overflow and inexact are both raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation present this cycle |
| form_i | input | 2 | 0 legacy, 1 plain, 2 masked |
| vlen_i | input | 2 | 0: 128, 1: 256, 2/3: 512 bits |
| zero_i | input | 1 | Zero masking (masked form) |
| bcast_i | input | 1 | Broadcast / override enable bit |
| src2_reg_i | input | 1 | Second operand comes from a register |
| rc_i | input | 2 | Override rounding mode |
| wmask_i | input | 16 | Per-lane write mask |
| src1_i | input | 512 | First source vector |
| src2_i | input | 512 | Second source vector |
| old_i | input | 512 | Previous destination contents |
| valid_o | output | 1 | Result present |
| dst_o | output | 512 | New destination vector |
| op_flags_o | output | 5 | Exception conditions of this operation |
| sticky_o | output | 5 | Accumulated exception conditions |

## Verification
The assertions check four things on every valid cycle. The legacy form must keep the upper lanes, and the other forms must clear the lanes above the active count. An all-zero mask must leave the old value under merge masking, and must give zeros with no flags under zero masking. The sticky flags must never lose a bit. Only the bench can show that each sum is correctly rounded, that broadcast and the rounding override apply only under their exact conditions, and how NaN, infinity, overflow, denormal and signed-zero cases come out. To do this it compares every lane with an independent real-number reference across all control combinations.

// File: rtl/vfadd_pkg.sv
package vfadd_pkg;

  typedef enum logic [1:0] {
    FORM_LEGACY = 2'd0,
    FORM_PLAIN  = 2'd1,
    FORM_MASKED = 2'd2
  } form_e;

  typedef enum logic [1:0] {
    RM_NE = 2'd0,
    RM_DN = 2'd1,
    RM_UP = 2'd2,
    RM_Z  = 2'd3
  } rmode_e;

  localparam int FL_DEN = 4;
  localparam int FL_INV = 3;
  localparam int FL_OVF = 2;
  localparam int FL_UNF = 1;
  localparam int FL_INX = 0;

  localparam logic [31:0] QNAN_DEFAULT = 32'h7FC0_0000;

  // Returns {flags[4:0], result[31:0]}
  function automatic logic [36:0] fp32_add(input logic [31:0] a, input logic [31:0] b,
                                           input logic [1:0] rm);
    logic [4:0]  fl;
    logic [31:0] r, big, sml;
    logic        a_nan, b_nan, a_snan, b_snan, a_inf, b_inf, sgn, up, inx, to_inf;
    logic [26:0] mx, my, my0, m;
    logic [27:0] s;
    logic [24:0] mant;
    int          ex, ey, d, lz, sh, e;
    fl = '0;
    r  = '0;
    a_nan  = (a[30:23] == 8'hFF) && (a[22:0] != 23'd0);
    b_nan  = (b[30:23] == 8'hFF) && (b[22:0] != 23'd0);
    a_snan = a_nan && !a[22];
    b_snan = b_nan && !b[22];
    a_inf  = (a[30:23] == 8'hFF) && (a[22:0] == 23'd0);
    b_inf  = (b[30:23] == 8'hFF) && (b[22:0] == 23'd0);
    if (a_nan || b_nan) begin
      if (a_snan || b_snan) begin
        r = QNAN_DEFAULT;
        fl[FL_INV] = 1'b1;
      end else begin
        r = a_nan ? a : b;
      end
    end else if (a_inf || b_inf) begin
      if (a_inf && b_inf && (a[31] != b[31])) begin
        r = QNAN_DEFAULT;
        fl[FL_INV] = 1'b1;
      end else begin
        r = a_inf ? a : b;
      end
    end else begin
      fl[FL_DEN] = ((a[30:23] == 8'd0) && (a[22:0] != 23'd0)) ||
                   ((b[30:23] == 8'd0) && (b[22:0] != 23'd0));
      if (a[30:0] >= b[30:0]) begin big = a; sml = b; end
      else begin big = b; sml = a; end
      sgn = big[31];
      ex  = (big[30:23] == 8'd0) ? 1 : int'(big[30:23]);
      ey  = (sml[30:23] == 8'd0) ? 1 : int'(sml[30:23]);
      mx  = {(big[30:23] != 8'd0), big[22:0], 3'b000};
      my0 = {(sml[30:23] != 8'd0), sml[22:0], 3'b000};
      d   = ex - ey;
      if (d >= 27) begin
        my = '0;
        my[0] = |my0;
      end else begin
        my = my0 >> d;
        my[0] = my[0] | (|(my0 & ((27'd1 << d) - 27'd1)));
      end
      if (big[31] == sml[31]) s = {1'b0, mx} + {1'b0, my};
      else                    s = {1'b0, mx} - {1'b0, my};
      if (s == 28'd0) begin
        r = {((big[31] == sml[31]) ? sgn : (rm == RM_DN)), 31'd0};
      end else begin
        if (s[27]) begin
          m = s[27:1];
          m[0] = m[0] | s[0];
          e = ex + 1;
        end else begin
          lz = 27;
          for (int i = 0; i <= 26; i++) if (s[i]) lz = 26 - i;
          sh = (lz < ex - 1) ? lz : ex - 1;
          m  = s[26:0] << sh;
          e  = ex - sh;
          if (!m[26]) e = 0;
        end
        inx = |m[2:0];
        case (rm)
          RM_NE:   up = m[2] & (m[1] | m[0] | m[3]);
          RM_DN:   up = inx & sgn;
          RM_UP:   up = inx & ~sgn;
          default: up = 1'b0;
        endcase
        mant = {1'b0, m[26:3]} + {24'd0, up};
        if (mant[24]) begin
          mant = mant >> 1;
          e = e + 1;
        end else if ((e == 0) && mant[23]) begin
          e = 1;
        end
        if (e >= 255) begin
          fl[FL_OVF] = 1'b1;
          inx = 1'b1;
          to_inf = (rm == RM_NE) || ((rm == RM_UP) && !sgn) || ((rm == RM_DN) && sgn);
          r = to_inf ? {sgn, 8'hFF, 23'd0} : {sgn, 8'hFE, 23'h7FFFFF};
        end else begin
          r = {sgn, e[7:0], mant[22:0]};
        end
        fl[FL_INX] = inx;
        fl[FL_UNF] = (e == 0) && inx;
      end
    end
    return {fl, r};
  endfunction

endpackage

// File: rtl/vfadd_ctrl.sv
module vfadd_ctrl
  import vfadd_pkg::*;
#(
  parameter int LANES = 16
) (
  input  logic [1:0]       form_i,
  input  logic [1:0]       vlen_i,
  input  logic             zero_i,
  input  logic             bcast_i,
  input  logic             src2_reg_i,
  input  logic [1:0]       rc_i,
  input  logic [LANES-1:0] wmask_i,
  output logic [LANES-1:0] take_o,
  output logic [LANES-1:0] clear_o,
  output logic             bcast_o,
  output logic [1:0]       rm_o
);
  logic             legacy, masked, zero_eff;
  logic [LANES-1:0] emask, active;
  int               span;

  assign legacy   = (form_i == FORM_LEGACY);
  assign masked   = (form_i == FORM_MASKED);
  assign zero_eff = masked & zero_i;
  assign emask    = masked ? wmask_i : '1;
  assign bcast_o  = masked & bcast_i & ~src2_reg_i;
  assign rm_o     = (masked && vlen_i[1] && src2_reg_i && bcast_i) ? rc_i : RM_NE;

  always_comb begin
    case (vlen_i)
      2'd0:    span = 4;
      2'd1:    span = 8;
      default: span = 16;
    endcase
    if (legacy) span = 4;
    if (span > LANES) span = LANES;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign active[i]  = (i < span);
    assign take_o[i]  = active[i] & emask[i];
    assign clear_o[i] = legacy ? 1'b0 : (active[i] ? (~emask[i] & zero_eff) : 1'b1);
  end
endmodule

// File: rtl/vfadd_lane.sv
module vfadd_lane
  import vfadd_pkg::*;
(
  input  logic [31:0] a_i,
  input  logic [31:0] b_i,
  input  logic [31:0] old_i,
  input  logic        take_i,
  input  logic        clear_i,
  input  logic [1:0]  rm_i,
  output logic [31:0] res_o,
  output logic [4:0]  flags_o
);
  logic [36:0] sum_fl;

  assign sum_fl  = fp32_add(a_i, b_i, rm_i);
  assign res_o   = take_i ? sum_fl[31:0] : (clear_i ? 32'd0 : old_i);
  assign flags_o = take_i ? sum_fl[36:32] : 5'd0;
endmodule

// File: rtl/vfadd_masked.sv
module vfadd_masked
  import vfadd_pkg::*;
#(
  parameter int LANES   = 16,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                valid_i,
  input  logic [1:0]          form_i,
  input  logic [1:0]          vlen_i,
  input  logic                zero_i,
  input  logic                bcast_i,
  input  logic                src2_reg_i,
  input  logic [1:0]          rc_i,
  input  logic [LANES-1:0]    wmask_i,
  input  logic [LANES*32-1:0] src1_i,
  input  logic [LANES*32-1:0] src2_i,
  input  logic [LANES*32-1:0] old_i,
  output logic                valid_o,
  output logic [LANES*32-1:0] dst_o,
  output logic [4:0]          op_flags_o,
  output logic [4:0]          sticky_o
);
  localparam int DW = LANES * 32;
  localparam int LO = 4 * 32;

  logic [LANES-1:0] take, clear;
  logic             bcast_eff;
  logic [1:0]       rm;
  logic [DW-1:0]    dst_c;
  logic [4:0]       lane_fl [LANES];
  logic [4:0]       fl_c;
  logic [4:0]       sticky_q;

  vfadd_ctrl #(.LANES(LANES)) u_ctrl (
    .form_i(form_i), .vlen_i(vlen_i), .zero_i(zero_i), .bcast_i(bcast_i),
    .src2_reg_i(src2_reg_i), .rc_i(rc_i), .wmask_i(wmask_i),
    .take_o(take), .clear_o(clear), .bcast_o(bcast_eff), .rm_o(rm)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [31:0] b_sel;
    assign b_sel = bcast_eff ? src2_i[31:0] : src2_i[i*32 +: 32];
    vfadd_lane u_lane (
      .a_i(src1_i[i*32 +: 32]), .b_i(b_sel), .old_i(old_i[i*32 +: 32]),
      .take_i(take[i]), .clear_i(clear[i]), .rm_i(rm),
      .res_o(dst_c[i*32 +: 32]), .flags_o(lane_fl[i])
    );
  end

  always_comb begin
    fl_c = '0;
    for (int i = 0; i < LANES; i++) fl_c = fl_c | lane_fl[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sticky_q <= '0;
    else if (valid_i) sticky_q <= sticky_q | fl_c;
  end
  assign sticky_o = sticky_q;

  a_r12_sticky_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sticky_o & $past(sticky_o)) == $past(sticky_o)));

  if (OUT_REG) begin : g_reg
    logic [DW-1:0] dst_q;
    logic [4:0]    fl_q;
    logic          vld_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dst_q <= '0;
        fl_q  <= '0;
        vld_q <= 1'b0;
      end else begin
        vld_q <= valid_i;
        if (valid_i) begin
          dst_q <= dst_c;
          fl_q  <= fl_c;
        end
      end
    end
    assign dst_o      = dst_q;
    assign op_flags_o = fl_q;
    assign valid_o    = vld_q;

    a_r5_zero_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && form_i == FORM_MASKED && zero_i && wmask_i == '0)
      |=> (dst_o == '0 && op_flags_o == 5'd0));

    a_r4_merge_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && form_i == FORM_MASKED && !zero_i && vlen_i[1] && wmask_i == '0)
      |=> (dst_o == $past(old_i)));

    if (LANES > 4) begin : g_upper_chk
      a_r2_legacy_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && form_i == FORM_LEGACY)
        |=> (dst_o[DW-1:LO] == $past(old_i[DW-1:LO])));

      a_r3_upper_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && form_i != FORM_LEGACY && vlen_i == 2'd0)
        |=> (dst_o[DW-1:LO] == '0));
    end
  end else begin : g_comb
    assign dst_o      = dst_c;
    assign op_flags_o = fl_c;
    assign valid_o    = valid_i;
  end
endmodule

// File: tb/tb_vfadd_masked.sv
module tb_vfadd_masked;
  localparam int CLK_NS = 10;
  localparam int NL = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_NS / 2) clk = ~clk;

  logic            valid_i = 1'b0;
  logic [1:0]      form_i = '0, vlen_i = '0, rc_i = '0;
  logic            zero_i = 1'b0, bcast_i = 1'b0, src2_reg_i = 1'b0;
  logic [NL-1:0]   wmask_i = '0;
  logic [NL*32-1:0] src1_i = '0, src2_i = '0, old_i = '0;
  logic            valid_o;
  logic [NL*32-1:0] dst_o;
  logic [4:0]      op_flags_o, sticky_o;

  vfadd_masked #(.LANES(NL), .OUT_REG(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .form_i(form_i), .vlen_i(vlen_i),
    .zero_i(zero_i), .bcast_i(bcast_i), .src2_reg_i(src2_reg_i), .rc_i(rc_i),
    .wmask_i(wmask_i), .src1_i(src1_i), .src2_i(src2_i), .old_i(old_i),
    .valid_o(valid_o), .dst_o(dst_o), .op_flags_o(op_flags_o), .sticky_o(sticky_o)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [4:0]  exp_sticky = '0;
  logic [31:0] rnd = 32'h1234_ABCD;
  logic [31:0] s1 [NL];
  logic [31:0] s2 [NL];
  logic [31:0] od [NL];

  function automatic logic [31:0] nxt();
    rnd = rnd * 32'd1103515245 + 32'd12345;
    return rnd;
  endfunction

  function automatic logic [31:0] gen_fp();
    logic [31:0] v;
    v = nxt();
    return {v[31], 8'd120 + 8'(v[27:24] % 4'd12), v[22:0]};
  endfunction

  function automatic real to_real(input logic [31:0] x);
    logic [10:0] ee;
    ee = 11'(x[30:23]) + 11'd896;
    return $bitstoreal({x[31], ee, x[22:0], 29'd0});
  endfunction

  // {inexact, fp32 bits}; valid for results in the normal range
  function automatic logic [32:0] ref_round(input real x, input logic [1:0] rm);
    logic [63:0] d;
    logic        sg, inx, up;
    logic [24:0] mm;
    logic [28:0] rest;
    int          ee;
    d = $realtobits(x);
    sg = d[63];
    if (d[62:0] == 63'd0) return {1'b0, (rm == 2'd1) ? 32'h8000_0000 : 32'h0};
    ee   = int'(d[62:52]) - 1023 + 127;
    rest = d[28:0];
    inx  = (rest != 29'd0);
    case (rm)
      2'd0:    up = rest[28] & ((|rest[27:0]) | d[29]);
      2'd1:    up = inx & sg;
      2'd2:    up = inx & ~sg;
      default: up = 1'b0;
    endcase
    mm = {2'b01, d[51:29]} + {24'd0, up};
    if (mm[24]) begin
      mm = mm >> 1;
      ee = ee + 1;
    end
    return {inx, sg, ee[7:0], mm[22:0]};
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] form, input logic [1:0] vlen, input logic zero,
                       input logic bc, input logic s2r, input logic [1:0] rc,
                       input logic [NL-1:0] mask);
    @(negedge clk);
    form_i = form; vlen_i = vlen; zero_i = zero; bcast_i = bc;
    src2_reg_i = s2r; rc_i = rc; wmask_i = mask;
    for (int i = 0; i < NL; i++) begin
      src1_i[i*32 +: 32] = s1[i];
      src2_i[i*32 +: 32] = s2[i];
      old_i[i*32 +: 32]  = od[i];
    end
    valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic run_op(input logic [1:0] form, input logic [1:0] vlen, input logic zero,
                        input logic bc, input logic s2r, input logic [1:0] rc,
                        input logic [NL-1:0] mask);
    int            nact;
    logic [NL-1:0] em;
    logic [1:0]    rm;
    logic          be;
    logic [4:0]    ef;
    logic [32:0]   rr;
    logic [31:0]   ev [NL];
    string         tmain, tup;
    for (int i = 0; i < NL; i++) begin
      s1[i] = gen_fp();
      s2[i] = gen_fp();
      od[i] = nxt();
    end
    nact = (form == 2'd0) ? 4 : (vlen == 2'd0) ? 4 : (vlen == 2'd1) ? 8 : 16;
    em   = (form == 2'd2) ? mask : '1;
    rm   = (form == 2'd2 && vlen[1] && s2r && bc) ? rc : 2'd0;
    be   = (form == 2'd2) && bc && !s2r;
    ef   = '0;
    for (int i = 0; i < NL; i++) begin
      if (i < nact) begin
        if (em[i]) begin
          rr = ref_round(to_real(s1[i]) + to_real(be ? s2[0] : s2[i]), rm);
          ev[i] = rr[31:0];
          ef[0] = ef[0] | rr[32];
        end else begin
          ev[i] = (form == 2'd2 && zero) ? 32'd0 : od[i];
        end
      end else begin
        ev[i] = (form == 2'd0) ? od[i] : 32'd0;
      end
    end
    if (form == 2'd0)      tmain = "R2";
    else if (form == 2'd1) tmain = "R6";
    else if (be)           tmain = "R7";
    else if (rm != 2'd0)   tmain = "R8";
    else if (zero)         tmain = "R5";
    else                   tmain = "R4";
    tup = (form == 2'd0) ? "R2" : "R3";
    apply(form, vlen, zero, bc, s2r, rc, mask);
    for (int i = 0; i < NL; i++) begin
      if (i >= nact)                      chk(tup, $sformatf("lane%0d upper", i), 64'(dst_o[i*32 +: 32]), 64'(ev[i]));
      else if (form == 2'd1 && i >= 4)    chk("R1", $sformatf("lane%0d count", i), 64'(dst_o[i*32 +: 32]), 64'(ev[i]));
      else                                chk(tmain, $sformatf("lane%0d", i), 64'(dst_o[i*32 +: 32]), 64'(ev[i]));
    end
    chk("R11", "op flags", 64'(op_flags_o), 64'(ef));
    exp_sticky = exp_sticky | ef;
  endtask

  // single lane 0 operation, masked form, src2 from register, broadcast bit set
  task automatic op1(input logic [31:0] a, input logic [31:0] b, input logic [1:0] vlen,
                     input logic [1:0] rc, input logic [31:0] er, input logic [4:0] ef,
                     input string tag);
    for (int i = 0; i < NL; i++) begin
      s1[i] = gen_fp(); s2[i] = gen_fp(); od[i] = nxt();
    end
    s1[0] = a;
    s2[0] = b;
    apply(2'd2, vlen, 1'b1, 1'b1, 1'b1, rc, 16'h0001);
    chk(tag, "lane0 result", 64'(dst_o[31:0]), 64'(er));
    chk(tag, "lane0 flags", 64'(op_flags_o), 64'(ef));
    exp_sticky = exp_sticky | ef;
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R13", "reset dst", 64'(|dst_o), 64'd0);
    chk("R13", "reset valid/flags", {57'd0, valid_o, op_flags_o, 1'b0}, 64'd0);
    chk("R12", "reset sticky", 64'(sticky_o), 64'd0);
    rst_n = 1'b1;

    // R13 latency: valid_o follows one clock after valid_i
    for (int i = 0; i < NL; i++) begin s1[i] = gen_fp(); s2[i] = gen_fp(); od[i] = '0; end
    @(negedge clk);
    valid_i = 1'b1; form_i = 2'd1; vlen_i = 2'd2;
    #(CLK_NS / 4);
    chk("R13", "valid_o before edge", 64'(valid_o), 64'd0);
    @(negedge clk);
    valid_i = 1'b0;
    chk("R13", "valid_o after edge", 64'(valid_o), 64'd1);
    @(negedge clk);
    chk("R13", "valid_o idle", 64'(valid_o), 64'd0);
    exp_sticky = sticky_o;

    // sweep over every control combination
    for (int f = 0; f < 3; f++)
      for (int v = 0; v < 4; v++)
        for (int z = 0; z < 2; z++)
          for (int bc = 0; bc < 2; bc++)
            for (int sr = 0; sr < 2; sr++)
              for (int rc = 0; rc < 4; rc++) begin
                logic [31:0] mk;
                mk = nxt();
                if (rc == 3 && sr == 0) mk = 32'd0;
                run_op(2'(f), 2'(v), 1'(z), 1'(bc), 1'(sr), 2'(rc), mk[NL-1:0]);
              end
    chk("R12", "sticky after sweep", 64'(sticky_o), 64'(exp_sticky));

    // rounding modes on a halfway case: 1 + 2^-24 and its negative
    op1(32'h3F80_0000, 32'h3380_0000, 2'd2, 2'd0, 32'h3F80_0000, 5'b00001, "R8");
    op1(32'h3F80_0000, 32'h3380_0000, 2'd2, 2'd2, 32'h3F80_0001, 5'b00001, "R8");
    op1(32'h3F80_0000, 32'h3380_0000, 2'd2, 2'd1, 32'h3F80_0000, 5'b00001, "R8");
    op1(32'h3F80_0000, 32'h3380_0000, 2'd2, 2'd3, 32'h3F80_0000, 5'b00001, "R8");
    op1(32'hBF80_0000, 32'hB380_0000, 2'd3, 2'd1, 32'hBF80_0001, 5'b00001, "R8");
    op1(32'hBF80_0000, 32'hB380_0000, 2'd2, 2'd2, 32'hBF80_0000, 5'b00001, "R8");
    // override ignored below 512 bits
    op1(32'h3F80_0000, 32'h3380_0000, 2'd1, 2'd2, 32'h3F80_0000, 5'b00001, "R8");
    // exact zero sign and denormal operands
    op1(32'h3F80_0000, 32'hBF80_0000, 2'd2, 2'd0, 32'h0000_0000, 5'b00000, "R9");
    op1(32'h3F80_0000, 32'hBF80_0000, 2'd2, 2'd1, 32'h8000_0000, 5'b00000, "R9");
    op1(32'h0000_0001, 32'h0000_0001, 2'd2, 2'd0, 32'h0000_0002, 5'b10000, "R9");
    op1(32'h0080_0001, 32'h8080_0000, 2'd2, 2'd0, 32'h0000_0001, 5'b00000, "R9");
    // NaN and infinity
    op1(32'h7F80_0000, 32'hFF80_0000, 2'd2, 2'd0, 32'h7FC0_0000, 5'b01000, "R10");
    op1(32'h7F80_0001, 32'h3F80_0000, 2'd2, 2'd0, 32'h7FC0_0000, 5'b01000, "R10");
    op1(32'h7FC0_0123, 32'h3F80_0000, 2'd2, 2'd0, 32'h7FC0_0123, 5'b00000, "R10");
    op1(32'h3F80_0000, 32'hFFC0_0456, 2'd2, 2'd0, 32'hFFC0_0456, 5'b00000, "R10");
    op1(32'h7F80_0000, 32'h3F80_0000, 2'd2, 2'd0, 32'h7F80_0000, 5'b00000, "R10");
    // overflow in each mode
    op1(32'h7F7F_FFFF, 32'h7F7F_FFFF, 2'd2, 2'd0, 32'h7F80_0000, 5'b00101, "R14");
    op1(32'h7F7F_FFFF, 32'h7F7F_FFFF, 2'd2, 2'd3, 32'h7F7F_FFFF, 5'b00101, "R14");
    op1(32'h7F7F_FFFF, 32'h7F7F_FFFF, 2'd2, 2'd2, 32'h7F80_0000, 5'b00101, "R14");
    op1(32'h7F7F_FFFF, 32'h7F7F_FFFF, 2'd2, 2'd1, 32'h7F7F_FFFF, 5'b00101, "R14");
    op1(32'hFF7F_FFFF, 32'hFF7F_FFFF, 2'd2, 2'd1, 32'hFF80_0000, 5'b00101, "R14");
    chk("R12", "sticky after corners", 64'(sticky_o), 64'(exp_sticky));

    // reset clears sticky; then accumulate from zero
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R12", "sticky cleared by reset", 64'(sticky_o), 64'd0);
    chk("R13", "dst cleared by reset", 64'(|dst_o), 64'd0);
    rst_n = 1'b1;
    exp_sticky = '0;
    op1(32'h4000_0000, 32'h3F80_0000, 2'd2, 2'd0, 32'h4040_0000, 5'b00000, "R12");
    chk("R12", "sticky after exact op", 64'(sticky_o), 64'd0);
    op1(32'h7F80_0000, 32'hFF80_0000, 2'd2, 2'd0, 32'h7FC0_0000, 5'b01000, "R12");
    op1(32'h3F80_0000, 32'h3380_0000, 2'd2, 2'd0, 32'h3F80_0000, 5'b00001, "R12");
    op1(32'h4000_0000, 32'h3F80_0000, 2'd2, 2'd0, 32'h4040_0000, 5'b00000, "R12");
    chk("R12", "sticky accumulated", 64'(sticky_o), 64'(5'b01001));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule